// File: doc/BRIEF.md
# SPI Chip-Select Sequencer

This block owns the chip-select lines of an SPI controller. A shift engine asks for a frame by raising a request level. The sequencer then asserts the line picked by the device index and counts a programmable lead guard. It grants the data phase, waits for the engine's end-of-frame pulse, counts a trail guard and releases the line. It then keeps the line released for a minimum idle time before it can assert again. Every guard is counted in SCK periods, using the one-cycle tick that the shift engine's clock divider already produces.

Each line has its own idle level, taken from a default vector. The selected line is driven to the opposite level and every other line stays at its default. Three select policies exist. In per-frame (auto) mode the line is released after each frame. In keep (hold) mode the line stays asserted across frames, separated only by an inter-frame gap, and is released only after a write to the index, default or mode field. In manual (off) mode frames are granted and no line ever moves away from its default.

Configuration uses a small write port with combinational read-back. Index 0 holds the device index in bits 4:0. Index 1 holds the default vector, one bit per line. Index 2 holds the mode in bits 1:0. Index 3 holds the lead guard in bits 7:0 and the trail guard in bits 23:16. Index 4 holds the idle guard in bits 7:0 and the inter-frame gap in bits 23:16.

Top module: `spi_select_seq`

## Requirements
- R1: After reset all lines sit at the reset default (all ones), the grant is low, the mode reads 0, index 3 reads 0x0001_0001 and index 4 reads 0x0000_0001.
- R2: Only the NCS implemented bits of the default vector are stored, and the bits above them read back as 0.
- R3: The selected line is driven to the inverse of its default bit and every other line to its default bit. A device index of NCS or more selects no line, but the frame is still granted.
- R4: From the cycle the line asserts until the grant rises, exactly the programmed lead count of SCK ticks elapses.
- R5: After the end-of-frame pulse in per-frame mode, the line stays asserted for exactly the trail count of ticks, with the grant low.
- R6: In per-frame mode, with frames back to back, the line stays released for exactly the idle count of ticks before it asserts again.
- R7: In keep mode (mode 2) the line stays asserted after a frame, indefinitely if no request follows. The next frame is granted after exactly the gap count of ticks, with no new lead guard.
- R8: In keep mode, a write to the index, default or mode field releases the line after exactly the trail count of ticks, measured from the cycle after the write.
- R9: In manual mode (mode 3) requests are granted and every line stays at its default level throughout.
- R10: While the grant is high in per-frame or keep mode with an in-range index, the selected line is asserted.
- R11: Mode value 1 behaves as per-frame mode and releases the line after each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration field index (0..4) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the field at cfg_addr |
| sck_tick | input | 1 | One-cycle pulse per SCK period from the divider |
| frame_req | input | 1 | Shift engine holds a frame ready to send |
| frame_done | input | 1 | Pulse on the last SCK edge of a frame |
| data_go | output | 1 | Grant: the shift engine may clock the frame |
| cs_o | output | NCS | Chip-select lines |

## Verification
A wrong state in this sequencer shows at the ports within one guard interval. An early or late phase change moves the grant edge or the select edge by whole SCK ticks, and the bench counts those ticks exactly against the programmed values. A lost keep state or a missed release shows as a line that changes level while no frame is running, or that never changes level after a write. A bad latch of index or polarity drives the wrong line, or the wrong level, in the first cycle of the lead guard.

// File: rtl/spi_select_seq.sv
`timescale 1ns/1ps
module spi_select_seq #(
  parameter int NCS = 8,
  parameter logic [NCS-1:0] RST_DFLT = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [2:0]     cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  input  logic           sck_tick,
  input  logic           frame_req,
  input  logic           frame_done,
  output logic           data_go,
  output logic [NCS-1:0] cs_o
);
  localparam int IW = 5;
  localparam logic [1:0] M_HOLD = 2'd2;
  localparam logic [1:0] M_OFF  = 2'd3;
  localparam logic [2:0] A_ID = 3'd0, A_DFLT = 3'd1, A_MODE = 3'd2, A_GRD0 = 3'd3, A_GRD1 = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_DATA, S_TRAIL, S_GAP, S_HOLD, S_INACT} st_t;

  logic [IW-1:0]  id_q, cur_id;
  logic [NCS-1:0] dflt_q;
  logic [1:0]     mode_q;
  logic [7:0]     lead_q, trail_q, idle_q, gap_q;
  st_t            st, st_nx;
  logic           drv, drv_nx, cur_pol, pol_nx, rel_pend, latch;
  logic [7:0]     cnt, tgt;
  logic           dly_done, rel_wr, rel_trig;

  wire is_hold = (mode_q == M_HOLD);
  wire is_off  = (mode_q == M_OFF);

  assign rel_wr   = cfg_wr && (cfg_addr == A_ID || cfg_addr == A_DFLT || cfg_addr == A_MODE);
  assign rel_trig = rel_pend || rel_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q    <= '0;
      dflt_q  <= RST_DFLT;
      mode_q  <= '0;
      lead_q  <= 8'd1;
      trail_q <= 8'd1;
      idle_q  <= 8'd1;
      gap_q   <= 8'd0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        A_ID:   id_q   <= cfg_wdata[IW-1:0];
        A_DFLT: dflt_q <= cfg_wdata[NCS-1:0];
        A_MODE: mode_q <= cfg_wdata[1:0];
        A_GRD0: begin lead_q <= cfg_wdata[7:0]; trail_q <= cfg_wdata[23:16]; end
        A_GRD1: begin idle_q <= cfg_wdata[7:0]; gap_q   <= cfg_wdata[23:16]; end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      A_ID:    cfg_rdata = 32'(id_q);
      A_DFLT:  cfg_rdata = 32'(dflt_q);
      A_MODE:  cfg_rdata = 32'(mode_q);
      A_GRD0:  cfg_rdata = {8'd0, trail_q, 8'd0, lead_q};
      A_GRD1:  cfg_rdata = {8'd0, gap_q, 8'd0, idle_q};
      default: cfg_rdata = '0;
    endcase
  end

  always_comb begin
    case (st)
      S_LEAD:  tgt = lead_q;
      S_TRAIL: tgt = trail_q;
      S_INACT: tgt = idle_q;
      S_GAP:   tgt = gap_q;
      default: tgt = '0;
    endcase
  end

  assign dly_done = (cnt == tgt) || (sck_tick && ({1'b0, cnt} + 9'd1 == {1'b0, tgt}));

  always_comb begin
    pol_nx = 1'b1;
    for (int i = 0; i < NCS; i++)
      if (id_q == IW'(i)) pol_nx = ~dflt_q[i];
  end

  always_comb begin
    st_nx  = st;
    drv_nx = drv;
    latch  = 1'b0;
    case (st)
      S_IDLE:
        if (frame_req) begin
          if (is_off) begin st_nx = S_DATA; drv_nx = 1'b0; end
          else begin st_nx = S_LEAD; drv_nx = 1'b1; latch = 1'b1; end
        end
      S_LEAD:
        if (dly_done) st_nx = S_DATA;
      S_DATA:
        if (frame_done) st_nx = (drv && (!is_hold || rel_trig)) ? S_TRAIL : S_GAP;
      S_TRAIL:
        if (dly_done) begin st_nx = S_INACT; drv_nx = 1'b0; end
      S_INACT:
        if (dly_done) begin
          if (!frame_req) st_nx = S_IDLE;
          else if (is_off) st_nx = S_DATA;
          else begin st_nx = S_LEAD; drv_nx = 1'b1; latch = 1'b1; end
        end
      S_GAP:
        if (dly_done) begin
          if (drv) begin
            if (rel_trig || !is_hold) st_nx = S_TRAIL;
            else if (frame_req)       st_nx = S_DATA;
            else                      st_nx = S_HOLD;
          end else begin
            st_nx = (frame_req && is_off) ? S_DATA : S_IDLE;
          end
        end
      S_HOLD:
        if (rel_trig || !is_hold) st_nx = S_TRAIL;
        else if (frame_req)       st_nx = S_DATA;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      drv      <= 1'b0;
      cur_id   <= '0;
      cur_pol  <= 1'b0;
      cnt      <= '0;
      rel_pend <= 1'b0;
    end else begin
      st  <= st_nx;
      drv <= drv_nx;
      if (latch) begin
        cur_id  <= id_q;
        cur_pol <= pol_nx;
      end
      if (st_nx != st)             cnt <= '0;
      else if (sck_tick && !dly_done) cnt <= cnt + 8'd1;
      if (st_nx == S_TRAIL || !drv_nx) rel_pend <= 1'b0;
      else if (rel_wr)                 rel_pend <= 1'b1;
    end
  end

  assign data_go = (st == S_DATA);

  for (genvar i = 0; i < NCS; i++) begin : g_line
    assign cs_o[i] = (drv && cur_id == IW'(i)) ? cur_pol : dflt_q[i];
  end

  p_idle_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (cs_o == dflt_q));

  p_inact_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INACT) |-> (cs_o == dflt_q));

  p_hold_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && is_hold && !rel_trig && !frame_req) |=> (st == S_HOLD && drv));

  p_done_ends_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go && frame_done) |=> !data_go);

  p_lead_drives_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LEAD) |=> drv);
endmodule

// File: tb/tb_spi_select_seq.sv
`timescale 1ns/1ps
module tb_spi_select_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sck_tick = 1'b0;
  logic        frame_req = 1'b0;
  logic        frame_done = 1'b0;
  logic        data_go;
  logic [7:0]  cs;
  int          tdiv = 0;
  int          checks = 0;
  int          fails = 0;
  int          tid = 0;
  logic [7:0]  tdflt = 8'hFF;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv     <= (tdiv == 3) ? 0 : tdiv + 1;
    sck_tick <= (tdiv == 3);
  end

  spi_select_seq #(.NCS(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sck_tick(sck_tick),
    .frame_req(frame_req), .frame_done(frame_done), .data_go(data_go), .cs_o(cs)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic bit asrt();
    return (tid < 8) && (cs[tid[2:0]] !== tdflt[tid[2:0]]);
  endfunction

  task automatic count_phase(input bit sel, output int n);
    n = 0;
    while ((asrt() == sel) && !data_go) begin
      if (sck_tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_go();
    while (!data_go) @(negedge clk);
  endtask

  task automatic end_frame(input bit more);
    repeat (3) @(negedge clk);
    frame_done = 1'b1; frame_req = more;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    chk(cs == 8'hFF, "R1 reset select levels", cs, 8'hFF);
    chk(data_go == 1'b0, "R1 reset grant", data_go, 0);
    rd(3'd2, v); chk(v == 32'd0, "R1 reset mode", v, 0);
    rd(3'd3, v); chk(v == 32'h0001_0001, "R1 reset lead/trail", v, 32'h0001_0001);
    rd(3'd4, v); chk(v == 32'h0000_0001, "R1 reset idle/gap", v, 1);
  endtask

  task automatic t_default_reg();
    logic [31:0] v;
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk(v == 32'h0000_00FF, "R2 unimplemented bits read 0", v, 32'hFF);
    wr(3'd1, 32'h1234_565A); tdflt = 8'h5A;
    rd(3'd1, v); chk(v == 32'h0000_005A, "R2 stored default", v, 32'h5A);
    @(negedge clk);
    chk(cs == 8'h5A, "R3 idle lines follow default", cs, 8'h5A);
  endtask

  task automatic t_auto();
    int n;
    wr(3'd0, 32'd2); tid = 2;
    wr(3'd3, 32'h0002_0003);
    wr(3'd4, 32'h0000_0004);
    @(negedge clk); frame_req = 1'b1;
    while (!asrt()) @(negedge clk);
    chk(cs == (8'h5A ^ 8'h04), "R3 selected line inverted", cs, 8'h5A ^ 8'h04);
    count_phase(1'b1, n); chk(n == 3, "R4 lead ticks", n, 3);
    chk(data_go && asrt(), "R10 selected during grant", cs, 8'h5A ^ 8'h04);
    end_frame(1'b1);
    count_phase(1'b1, n); chk(n == 2, "R5 trail ticks", n, 2);
    count_phase(1'b0, n); chk(n == 4, "R6 idle ticks between frames", n, 4);
    count_phase(1'b1, n); chk(n == 3, "R4 lead ticks second frame", n, 3);
    wait_go();
    end_frame(1'b0);
    count_phase(1'b1, n); chk(n == 2, "R5 trail ticks last frame", n, 2);
    repeat (30) @(negedge clk);
    chk(cs == tdflt, "R5 released after frame", cs, tdflt);
  endtask

  task automatic t_out_of_range();
    wr(3'd0, 32'd12); tid = 12;
    @(negedge clk); frame_req = 1'b1;
    wait_go();
    chk(cs == tdflt, "R3 out-of-range index selects none", cs, tdflt);
    end_frame(1'b0);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_hold_release();
    int n;
    wr(3'd0, 32'd5); tid = 5;
    wr(3'd2, 32'd2);
    wr(3'd3, 32'h0002_0001);
    wr(3'd4, 32'h0003_0001);
    @(negedge clk); frame_req = 1'b1;
    while (!asrt()) @(negedge clk);
    wait_go();
    end_frame(1'b1);
    count_phase(1'b1, n); chk(n == 3, "R7 gap ticks, no lead", n, 3);
    chk(data_go == 1'b1, "R7 second frame granted", data_go, 1);
    end_frame(1'b0);
    repeat (40) @(negedge clk);
    chk(asrt(), "R7 select kept after frame", cs, 8'h5A ^ 8'h20);
    wr(3'd0, 32'd3);
    count_phase(1'b1, n); chk(n == 2, "R8 trail ticks before release", n, 2);
    chk(cs == tdflt, "R8 released after write", cs, tdflt);
    tid = 3;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_off();
    int grants = 0;
    bit moved = 0;
    wr(3'd2, 32'd3);
    @(negedge clk); frame_req = 1'b1;
    for (int f = 0; f < 2; f++) begin
      while (!data_go) begin
        if (cs !== tdflt) moved = 1;
        @(negedge clk);
      end
      grants++;
      if (cs !== tdflt) moved = 1;
      end_frame(f == 0);
    end
    repeat (20) begin
      if (cs !== tdflt) moved = 1;
      @(negedge clk);
    end
    chk(grants == 2, "R9 frames granted in manual mode", grants, 2);
    chk(!moved, "R9 lines never leave default", moved, 0);
  endtask

  task automatic t_mode1();
    wr(3'd2, 32'd1);
    wr(3'd0, 32'd2); tid = 2;
    wr(3'd3, 32'h0000_0000);
    wr(3'd4, 32'h0000_0000);
    @(negedge clk); frame_req = 1'b1;
    while (!asrt()) @(negedge clk);
    wait_go();
    end_frame(1'b0);
    repeat (5) @(negedge clk);
    chk(cs == tdflt, "R11 mode 1 releases like per-frame", cs, tdflt);
  endtask

  initial begin
    #(8ns * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_reg();
    t_auto();
    t_out_of_range();
    t_hold_release();
    t_off();
    t_mode1();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule